// File: doc/BRIEF.md
# Multichannel ADC Serial Frame Controller

This block is the system-side master for a 16-input, 12-bit successive-approximation converter that is reached over a chip-select-framed serial link. Each frame pulls chip select low, which samples the selected input and starts the conversion. The block then toggles the serial clock for exactly sixteen cycles, and that clock also paces the conversion. During those cycles it sends a 16-bit control word to the converter and collects a 16-bit reply. The reply holds a 4-bit channel tag followed by the 12-bit result, most significant bit first. Chip select then goes high again and a quiet gap is kept before the next frame may start.

All serial timing comes from the system clock, using counts that are set by parameters: the serial half-period, the setup from chip-select fall to the first clock edge, the hold from the last falling edge to chip-select rise, the quiet gap, and the power-up wait. Software places the control word in a register port. Frames start on a single start pulse or back to back while a run level is held. Each result leaves on a valid/ready stream carrying its channel number and a flag that gives the output coding in force when that conversion was requested. A wake request adds the power-up wait before the next frame.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, chip select and the serial clock are both high and no result is valid.
- R2: Each frame gives exactly 16 serial-clock falling edges while chip select is low. The serial clock toggles only while chip select is low, and chip select changes only while the serial clock is high.
- R3: Within a frame, every serial-clock high phase and every low phase lasts HALF_CYC system cycles.
- R4: The control word goes out on the data-to-converter line with bit 15 first. The bit is valid from chip-select fall, each new bit appears on a serial-clock rising edge, and the line is steady across every falling edge.
- R5: The block samples the converter's data line in the system cycle that drives each falling edge. Of the 16 bits collected, the first four are the channel tag and the last twelve are the result, most significant bit first.
- R6: The first falling edge comes SETUP_CYC+HALF_CYC cycles after chip select falls. Chip select rises HALF_CYC+HOLD_CYC cycles after the 16th falling edge.
- R7: Between frames run back to back with no wake request, chip select stays high for exactly QUIET_CYC+1 cycles.
- R8: The coding flag of a result equals bit 4 of the control word sent in the most recent earlier frame whose bit 15 was 1 (1 means twos complement). The flag is 0 if no such frame has occurred since reset.
- R9: A frame whose control word has bit 15 equal to 0 leaves the coding state unchanged for later results.
- R10: After a wake pulse, the next chip-select high gap grows by exactly WAKE_CYC cycles.
- R11: While a result is valid and not accepted, its data, channel and coding flag stay stable, and no new frame starts.
- R12: With the run level low, one start pulse produces exactly one frame. With run high and results accepted, frames follow one another continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request for a single frame |
| run | input | 1 | Level that keeps frames running back to back |
| wake | input | 1 | One-cycle request to add the power-up wait before the next frame |
| ctrl_we | input | 1 | Write strobe for the control word register |
| ctrl_wd | input | 16 | Control word value |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdo | output | 1 | Serial data to the converter |
| sdi | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted by the consumer |
| res_chan | output | 4 | Channel tag of the result |
| res_data | output | 12 | Conversion result |
| res_twos | output | 1 | Coding flag: 1 means twos complement |

## Verification
The bench builds the block with HALF_CYC=2, SETUP_CYC=1, HOLD_CYC=1, QUIET_CYC=3 and WAKE_CYC=10, so one frame takes only a few dozen cycles. This lets every timing window be measured exactly, to the cycle. A behavioural converter model in the bench loads a known tagged frame on each chip-select fall, moves its data on falling edges and records the bits it receives. Exact expected values for the setup, hold, phase, quiet and wake intervals therefore follow from the parameters, and a short chain of frames walks the coding flag through its write-enabled and write-ignored cases.

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int HALF_CYC  = 5,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 2,
  parameter int QUIET_CYC = 5,
  parameter int WAKE_CYC  = 100,
  parameter int CHAN_W    = 4,
  parameter int DATA_W    = 12,
  parameter int WR_BIT    = 15,
  parameter int COD_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              wake,
  input  logic              ctrl_we,
  input  logic [15:0]       ctrl_wd,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CHAN_W-1:0] res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              res_twos
);
  localparam int FB = CHAN_W + DATA_W;
  localparam int NW = $clog2(FB + 1);
  localparam int TW = $clog2(WAKE_CYC + QUIET_CYC + SETUP_CYC + HOLD_CYC + HALF_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_SETUP, S_SHIFT, S_HOLD, S_QUIET} st_t;

  st_t          st;
  logic [TW-1:0] tmr;
  logic [NW-1:0] nfall;
  logic [15:0]   ctrl_q, sho;
  logic [FB-1:0] shi;
  logic          w_we, w_cod, cod_act;
  logic          pend_go, pend_wake;

  wire go   = (pend_go || start || run) && !res_valid;
  wire wk   = pend_wake || wake;
  wire tick = (tmr == TW'(HALF_CYC - 1));

  assign sdo = sho[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; nfall <= '0;
      cs_n <= 1'b1; sclk <= 1'b1;
      sho <= '0; shi <= '0;
      w_we <= 1'b0; w_cod <= 1'b0; cod_act <= 1'b0;
      pend_go <= 1'b0; pend_wake <= 1'b0;
      res_valid <= 1'b0; res_chan <= '0; res_data <= '0; res_twos <= 1'b0;
    end else begin
      if (start) pend_go <= 1'b1;
      if (wake) pend_wake <= 1'b1;
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          pend_go <= 1'b0;
          tmr <= '0;
          if (wk) begin
            pend_wake <= 1'b0;
            st <= S_WAKE;
          end else begin
            st <= S_SETUP; cs_n <= 1'b0; sho <= ctrl_q;
            w_we <= ctrl_q[WR_BIT]; w_cod <= ctrl_q[COD_BIT];
          end
        end
        S_WAKE: if (tmr == TW'(WAKE_CYC - 1)) begin
          tmr <= '0; st <= S_SETUP; cs_n <= 1'b0; sho <= ctrl_q;
          w_we <= ctrl_q[WR_BIT]; w_cod <= ctrl_q[COD_BIT];
        end else tmr <= tmr + 1'b1;
        S_SETUP: if (tmr == TW'(SETUP_CYC - 1)) begin
          tmr <= '0; nfall <= '0; st <= S_SHIFT;
        end else tmr <= tmr + 1'b1;
        S_SHIFT: if (tick) begin
          tmr <= '0;
          sclk <= ~sclk;
          if (sclk) begin
            shi <= {shi[FB-2:0], sdi};
            nfall <= nfall + 1'b1;
          end else if (nfall == NW'(FB)) st <= S_HOLD;
          else sho <= {sho[14:0], 1'b0};
        end else tmr <= tmr + 1'b1;
        S_HOLD: if (tmr == TW'(HOLD_CYC - 1)) begin
          tmr <= '0; cs_n <= 1'b1; st <= S_QUIET;
          res_valid <= 1'b1;
          res_chan <= shi[FB-1:DATA_W];
          res_data <= shi[DATA_W-1:0];
          res_twos <= cod_act;
          if (w_we) cod_act <= w_cod;
        end else tmr <= tmr + 1'b1;
        S_QUIET: if (tmr == TW'(QUIET_CYC - 1)) begin
          tmr <= '0; st <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_clk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !cs_n);
  p_cs_at_clk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> sclk);
  p_sixteen_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> nfall == NW'(FB));
  p_sdo_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$stable(sdo)) |-> ($rose(sclk) || $fell(cs_n)));
  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan) && $stable(res_twos)));
  p_no_start_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !res_valid);
endmodule

// File: tb/adc_frame_ctrl_test.sv
module adc_frame_ctrl_test;
  localparam int HALF = 2, SET = 1, HLD = 1, QT = 3, WK = 10;

  logic clk = 0, rst_n = 0, start = 0, run = 0, wake = 0, ctrl_we = 0, res_ready = 1;
  logic [15:0] ctrl_wd = '0;
  logic cs_n, sclk, sdo, sdi, res_valid, res_twos;
  logic [3:0] res_chan;
  logic [11:0] res_data;

  adc_frame_ctrl #(.HALF_CYC(HALF), .SETUP_CYC(SET), .HOLD_CYC(HLD), .QUIET_CYC(QT), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .wake(wake),
    .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan), .res_data(res_data), .res_twos(res_twos));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;

  // converter model
  logic [15:0] adc_frame = '0, adc_sh = '0, rx = '0;
  assign sdi = adc_sh[15];
  always @(negedge cs_n or negedge sclk) begin
    if (sclk === 1'b1) begin adc_sh = adc_frame; rx = '0; end
    else if (cs_n === 1'b0) begin rx = {rx[14:0], sdo}; adc_sh = adc_sh << 1; end
  end

  // timing monitor
  int cyc = 0, frames = 0, t_fall = 0, t_rise = 0, t_edge = 0, t_first = 0, t_last = 0;
  int gap = 0, falls = 0, phmin = 0, phmax = 0;
  bit had_edge = 0;
  logic pcs = 1, psc = 1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pcs && !cs_n) begin
        frames++; t_fall = cyc; gap = cyc - t_rise; falls = 0;
        phmin = 1000; phmax = 0; had_edge = 0;
      end
      if (!pcs && cs_n) t_rise = cyc;
      if (psc != sclk) begin
        if (had_edge) begin
          if (cyc - t_edge < phmin) phmin = cyc - t_edge;
          if (cyc - t_edge > phmax) phmax = cyc - t_edge;
        end
        had_edge = 1; t_edge = cyc;
        if (!sclk) begin falls++; if (falls == 1) t_first = cyc; t_last = cyc; end
      end
    end
    pcs = cs_n; psc = sclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_word(input logic [15:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wd = w;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wait_res();
    while (!res_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 1);
    chk("R1 res_valid", res_valid, 0);
  endtask

  task automatic one_frame(input logic [15:0] w, input logic [15:0] f, input int exp_twos, input string tag);
    int f0;
    set_word(w);
    adc_frame = f;
    f0 = frames;
    start = 1; @(negedge clk); start = 0;
    wait_res();
    @(negedge clk); @(negedge clk);
    chk({tag, " R5 chan"}, res_chan, f[15:12]);
    chk({tag, " R5 data"}, res_data, f[11:0]);
    chk({tag, " R4 word"}, rx, w);
    chk({tag, " R8 coding"}, res_twos, exp_twos);
    chk({tag, " R2 falls"}, falls, 16);
    chk({tag, " R3 phmin"}, phmin, HALF);
    chk({tag, " R3 phmax"}, phmax, HALF);
    chk({tag, " R6 setup"}, t_first - t_fall, SET + HALF);
    chk({tag, " R6 hold"}, t_rise - t_last, HALF + HLD);
    repeat (40) @(negedge clk);
    chk({tag, " R12 single"}, frames - f0, 1);
  endtask

  task automatic t_coding();
    one_frame(16'h8010, 16'h5ABC, 0, "A");
    one_frame(16'h0000, 16'hF123, 1, "B");
    one_frame(16'h8000, 16'h0FFF, 1, "C R9");
    one_frame(16'hC3A0, 16'hA800, 0, "D");
  endtask

  task automatic t_run_wake();
    int f0;
    res_ready = 1; adc_frame = 16'h3456; run = 1;
    f0 = frames;
    while (frames < f0 + 3) @(negedge clk);
    @(negedge clk);
    chk("R7 gap", gap, QT + 1);
    chk("R12 run", frames - f0, 3);
    wake = 1; @(negedge clk); wake = 0;
    f0 = frames;
    while (frames == f0) @(negedge clk);
    @(negedge clk);
    chk("R10 wake gap", gap, QT + 1 + WK);
    f0 = frames;
    while (frames == f0) @(negedge clk);
    @(negedge clk);
    chk("R10 after wake", gap, QT + 1);
    run = 0;
    wait_res();
    repeat (60) @(negedge clk);
  endtask

  task automatic t_stall();
    int f0;
    logic [11:0] d0;
    res_ready = 0; adc_frame = 16'h7E01; run = 1;
    wait_res();
    f0 = frames; d0 = res_data;
    repeat (100) @(negedge clk);
    chk("R11 no frame", frames - f0, 0);
    chk("R11 valid held", res_valid, 1);
    chk("R11 data held", res_data, d0);
    chk("R11 data value", res_data, 12'hE01);
    res_ready = 1;
    repeat (40) @(negedge clk);
    chk("R11 resumes", (frames > f0) ? 1 : 0, 1);
    run = 0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_coding();
    t_run_wake();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule